// File: doc/BRIEF.md
# Virtual-ISA Integer Execution Unit

This block is the integer datapath of a virtual instruction set interpreter. An operation code, a 64-bit operand A and a 64-bit operand B arrive with a valid strobe. One clock edge later the block returns a 64-bit result C with a matching one-cycle valid flag. It has no pipeline stalls and keeps no state beyond the output register, so the issuing logic can send one operation every cycle.

The operations are:
- add and subtract, which wrap modulo 2^64;
- bitwise AND, OR and XOR;
- four kinds of multiply: the low half of the 64x64 product, the unsigned high half, the signed high half, and the full 64-bit products of the low 32-bit halves, signed and unsigned;
- logical and arithmetic shifts;
- rotates.

Add, subtract and the logic operations also come in 32-bit forms that zero the upper half of C. Shifts and rotates take their amount only from the lowest six bits of B. Op codes that are not assigned pass A through.

Top module: `vx_int_alu`

## Requirements
- R1: With op 0 (add) C = (A + B) mod 2^64, and with op 2 (subtract) C = (A - B) mod 2^64.
- R2: Ops 1 (add32), 3 (sub32), 10 (and32), 12 (or32) and 14 (xor32) use only A[31:0] and B[31:0], place the 32-bit result in C[31:0], and set C[63:32] to zero.
- R3: Ops 9 (and), 11 (or) and 13 (xor) return the full 64-bit bitwise AND, OR and XOR of A and B.
- R4: Op 4 returns bits 63:0 and op 5 returns bits 127:64 of the unsigned 128-bit product A*B.
- R5: Op 6 returns bits 127:64 of the product of A and B, with both read as two's complement 64-bit numbers.
- R6: Op 7 returns the full 64-bit unsigned product of A[31:0] and B[31:0]. Op 8 returns the full 64-bit signed product of the same halves, each read as two's complement.
- R7: Ops 15 (shift left), 16 (logical shift right), 17 (arithmetic shift right), 18 (rotate left) and 19 (rotate right) take the amount from B[5:0]. B[63:6] has no effect on them.
- R8: Op 17 fills the vacated upper positions with A[63]. Op 16 fills them with zero.
- R9: Ops 18 and 19 rotate A left or right, and bits leaving one end re-enter at the other.
- R10: A shift or rotate (ops 15 to 19) with B[5:0] = 0 returns A unchanged.
- R11: Op codes 20 to 31 return A unchanged.
- R12: When in_valid is high at a rising edge, out_valid is high after that edge and C holds that operation's result. When in_valid is low, out_valid is low after the edge. Reset clears out_valid and C.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands and op code are valid this cycle |
| op | input | 5 | Operation code |
| opa | input | 64 | Operand A |
| opb | input | 64 | Operand B |
| out_valid | output | 1 | Result register holds a new result |
| res | output | 64 | Result C |

## Verification
The only state is the output register and its valid flag, so any wrong internal behaviour shows up at the ports one cycle after the operation is accepted.
- A wrong class select or operand extension produces a wrong C on that same result.
- A dropped or duplicated valid shows up as a missing or extra result, which the scoreboard queue catches at the next compare or when the run drains.
- Zero-extension errors, pass-through of unused op codes and zero-amount shifts are also checked on every result by bound properties.

// File: rtl/vx_alu_pkg.sv
package vx_alu_pkg;
  localparam int OPW = 5;

  typedef enum logic [OPW-1:0] {
    OP_ADD64  = 5'd0,
    OP_ADD32  = 5'd1,
    OP_SUB64  = 5'd2,
    OP_SUB32  = 5'd3,
    OP_MULLO  = 5'd4,
    OP_MULHU  = 5'd5,
    OP_MULHS  = 5'd6,
    OP_MULU32 = 5'd7,
    OP_MULS32 = 5'd8,
    OP_AND64  = 5'd9,
    OP_AND32  = 5'd10,
    OP_OR64   = 5'd11,
    OP_OR32   = 5'd12,
    OP_XOR64  = 5'd13,
    OP_XOR32  = 5'd14,
    OP_SHL    = 5'd15,
    OP_SHR    = 5'd16,
    OP_SAR    = 5'd17,
    OP_ROL    = 5'd18,
    OP_ROR    = 5'd19
  } vx_op_e;

  typedef enum logic [1:0] {
    CL_PASS  = 2'd0,
    CL_ADDLG = 2'd1,
    CL_MUL   = 2'd2,
    CL_SHIFT = 2'd3
  } vx_class_e;

  function automatic vx_class_e op_class(input logic [OPW-1:0] op);
    case (op)
      OP_ADD64, OP_ADD32, OP_SUB64, OP_SUB32,
      OP_AND64, OP_AND32, OP_OR64, OP_OR32,
      OP_XOR64, OP_XOR32:                       return CL_ADDLG;
      OP_MULLO, OP_MULHU, OP_MULHS,
      OP_MULU32, OP_MULS32:                     return CL_MUL;
      OP_SHL, OP_SHR, OP_SAR, OP_ROL, OP_ROR:   return CL_SHIFT;
      default:                                  return CL_PASS;
    endcase
  endfunction
endpackage

// File: rtl/vx_alu_addlog.sv
module vx_alu_addlog
  import vx_alu_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [OPW-1:0]  op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] y
);
  localparam int HALF = XLEN / 2;

  logic [XLEN-1:0] wide;
  logic            narrow;

  always_comb begin
    narrow = 1'b0;
    case (op)
      OP_ADD64, OP_ADD32: wide = a + b;
      OP_SUB64, OP_SUB32: wide = a - b;
      OP_AND64, OP_AND32: wide = a & b;
      OP_OR64,  OP_OR32:  wide = a | b;
      default:            wide = a ^ b;
    endcase
    case (op)
      OP_ADD32, OP_SUB32, OP_AND32, OP_OR32, OP_XOR32: narrow = 1'b1;
      default:                                         narrow = 1'b0;
    endcase
    // low half of each of these depends only on the low operand halves
    y = narrow ? {{(XLEN-HALF){1'b0}}, wide[HALF-1:0]} : wide;
  end
endmodule

// File: rtl/vx_alu_mul.sv
module vx_alu_mul
  import vx_alu_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [OPW-1:0]  op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] y
);
  localparam int HALF = XLEN / 2;
  localparam int PW   = 2 * XLEN + 2;

  logic signed [XLEN:0] ma, mb;
  logic signed [PW-1:0] prod;
  logic                 take_hi;

  always_comb begin
    take_hi = 1'b0;
    case (op)
      OP_MULHS: begin
        ma = {a[XLEN-1], a};
        mb = {b[XLEN-1], b};
        take_hi = 1'b1;
      end
      OP_MULHU: begin
        ma = {1'b0, a};
        mb = {1'b0, b};
        take_hi = 1'b1;
      end
      OP_MULU32: begin
        ma = {{(XLEN-HALF+1){1'b0}}, a[HALF-1:0]};
        mb = {{(XLEN-HALF+1){1'b0}}, b[HALF-1:0]};
      end
      OP_MULS32: begin
        ma = {{(XLEN-HALF+1){a[HALF-1]}}, a[HALF-1:0]};
        mb = {{(XLEN-HALF+1){b[HALF-1]}}, b[HALF-1:0]};
      end
      default: begin
        ma = {1'b0, a};
        mb = {1'b0, b};
      end
    endcase
  end

  assign prod = PW'(ma) * PW'(mb);
  assign y    = XLEN'(take_hi ? (prod >>> XLEN) : prod);
endmodule

// File: rtl/vx_alu_shift.sv
module vx_alu_shift
  import vx_alu_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int SHW  = $clog2(XLEN)
) (
  input  logic [OPW-1:0]  op,
  input  logic [XLEN-1:0] a,
  input  logic [SHW-1:0]  amt,
  output logic [XLEN-1:0] y
);
  logic [SHW:0] inv;

  assign inv = (SHW+1)'(XLEN) - {1'b0, amt};

  always_comb begin
    case (op)
      OP_SHL:  y = a << amt;
      OP_SHR:  y = a >> amt;
      OP_SAR:  y = $unsigned($signed(a) >>> amt);
      OP_ROL:  y = (a << amt) | (a >> inv);
      default: y = (a >> amt) | (a << inv);
    endcase
  end
endmodule

// File: rtl/vx_int_alu.sv
module vx_int_alu
  import vx_alu_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int SHW  = $clog2(XLEN)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [4:0]      op,
  input  logic [XLEN-1:0] opa,
  input  logic [XLEN-1:0] opb,
  output logic            out_valid,
  output logic [XLEN-1:0] res
);
  logic [XLEN-1:0] y_al, y_mul, y_sh, y_next;

  vx_alu_addlog #(.XLEN(XLEN)) u_addlog (
    .op(op), .a(opa), .b(opb), .y(y_al)
  );

  vx_alu_mul #(.XLEN(XLEN)) u_mul (
    .op(op), .a(opa), .b(opb), .y(y_mul)
  );

  vx_alu_shift #(.XLEN(XLEN), .SHW(SHW)) u_shift (
    .op(op), .a(opa), .amt(opb[SHW-1:0]), .y(y_sh)
  );

  always_comb begin
    case (op_class(op))
      CL_ADDLG: y_next = y_al;
      CL_MUL:   y_next = y_mul;
      CL_SHIFT: y_next = y_sh;
      default:  y_next = opa;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      res       <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) res <= y_next;
    end
  end
endmodule

// File: rtl/vx_int_alu_chk.sv
module vx_int_alu_chk #(
  parameter int XLEN = 64,
  parameter int SHW  = $clog2(XLEN)
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic [4:0]      op,
  input logic [XLEN-1:0] opa,
  input logic [XLEN-1:0] opb,
  input logic            out_valid,
  input logic [XLEN-1:0] res
);
  localparam int HALF = XLEN / 2;

  assert_valid_follows_R12: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  assert_idle_follows_R12: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  assert_zero_upper_R2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (op == 5'd1 || op == 5'd3 || op == 5'd10 || op == 5'd12 || op == 5'd14))
    |=> (res[XLEN-1:HALF] == '0));

  assert_unused_pass_R11: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op >= 5'd20) |=> (res == $past(opa)));

  assert_zero_amount_R10: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op >= 5'd15 && op <= 5'd19 && opb[SHW-1:0] == '0) |=> (res == $past(opa)));

  assert_and_full_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 5'd9) |=> (res == ($past(opa) & $past(opb))));
endmodule

bind vx_int_alu vx_int_alu_chk #(.XLEN(XLEN), .SHW(SHW)) u_chk (.*);

// File: tb/vx_int_alu_tb.sv
module vx_int_alu_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [4:0]  op = '0;
  logic [63:0] opa = '0, opb = '0;
  logic        out_valid;
  logic [63:0] res;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [63:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  vx_int_alu u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op),
    .opa(opa), .opb(opb), .out_valid(out_valid), .res(res)
  );

  function automatic logic [63:0] model(input logic [4:0] o, input logic [63:0] a, input logic [63:0] b);
    logic [127:0] p;
    logic [5:0]   s;
    s = b[5:0];
    case (o)
      5'd0:  return a + b;
      5'd1:  return {32'h0, a[31:0] + b[31:0]};
      5'd2:  return a - b;
      5'd3:  return {32'h0, a[31:0] - b[31:0]};
      5'd4:  begin p = {64'h0, a} * {64'h0, b}; return p[63:0]; end
      5'd5:  begin p = {64'h0, a} * {64'h0, b}; return p[127:64]; end
      5'd6:  begin p = {{64{a[63]}}, a} * {{64{b[63]}}, b}; return p[127:64]; end
      5'd7:  return {32'h0, a[31:0]} * {32'h0, b[31:0]};
      5'd8:  return {{32{a[31]}}, a[31:0]} * {{32{b[31]}}, b[31:0]};
      5'd9:  return a & b;
      5'd10: return {32'h0, a[31:0] & b[31:0]};
      5'd11: return a | b;
      5'd12: return {32'h0, a[31:0] | b[31:0]};
      5'd13: return a ^ b;
      5'd14: return {32'h0, a[31:0] ^ b[31:0]};
      5'd15: return a << s;
      5'd16: return a >> s;
      5'd17: begin
        logic [63:0] r;
        r = a;
        for (int i = 0; i < 64; i++) if (i < s) r = {r[63], r[63:1]};
        return r;
      end
      5'd18: begin
        logic [63:0] r;
        r = a;
        for (int i = 0; i < 64; i++) if (i < s) r = {r[62:0], r[63]};
        return r;
      end
      5'd19: begin
        logic [63:0] r;
        r = a;
        for (int i = 0; i < 64; i++) if (i < s) r = {r[0], r[63:1]};
        return r;
      end
      default: return a;
    endcase
  endfunction

  task automatic send(input logic [4:0] o, input logic [63:0] a, input logic [63:0] b,
                      input logic [63:0] e, input string tag);
    @(negedge clk);
    in_valid = 1'b1; op = o; opa = a; opb = b;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  always @(negedge clk) begin
    if (!rst && out_valid && !done) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R12: unexpected result %h, expected none", res);
      end else begin
        logic [63:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (res !== e) begin
          errors++;
          $display("FAIL %s: got %h expected %h", t, res, e);
        end
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R12: watchdog expired, got hang expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || res !== 64'h0) begin
      errors++;
      $display("FAIL R12: reset state got %b/%h expected 0/0", out_valid, res);
    end
    rst = 1'b0;

    // R1 wrap
    send(5'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 64'h0, "R1 add wrap");
    send(5'd2, 64'h0, 64'h1, 64'hFFFF_FFFF_FFFF_FFFF, "R1 sub wrap");
    // R2 narrow forms
    send(5'd1, 64'hAAAA_AAAA_FFFF_FFFF, 64'h5555_5555_0000_0001, 64'h0, "R2 add32");
    send(5'd3, 64'h1234_0000_0000_0000, 64'h1, 64'h0000_0000_FFFF_FFFF, "R2 sub32");
    send(5'd10, '1, '1, 64'h0000_0000_FFFF_FFFF, "R2 and32");
    send(5'd12, 64'hF0F0_0000_0000_00F0, 64'h0F0F_0000_0000_000F, 64'h0000_0000_0000_00FF, "R2 or32");
    send(5'd14, '1, 64'h0000_0001_0000_FFFF, 64'h0000_0000_FFFF_0000, "R2 xor32");
    // R3 logic
    send(5'd9, 64'hFF00_FF00_1234_5678, 64'h0FF0_0FF0_FFFF_0000, 64'h0F00_0F00_1234_0000, "R3 and");
    send(5'd11, 64'hF000_0000_0000_0000, 64'h0000_0000_0000_000F, 64'hF000_0000_0000_000F, "R3 or");
    send(5'd13, '1, 64'h8000_0000_0000_0001, 64'h7FFF_FFFF_FFFF_FFFE, "R3 xor");
    // R4 unsigned 64x64
    send(5'd4, '1, '1, 64'h1, "R4 mul low");
    send(5'd5, '1, '1, 64'hFFFF_FFFF_FFFF_FFFE, "R4 mul high unsigned");
    // R5 signed high
    send(5'd6, '1, '1, 64'h0, "R5 signed high -1*-1");
    send(5'd6, 64'h8000_0000_0000_0000, 64'h2, '1, "R5 signed high min*2");
    // R6 32x32
    send(5'd7, 64'hDEAD_0000_FFFF_FFFF, 64'h1_FFFF_FFFF, 64'hFFFF_FFFE_0000_0001, "R6 mulu32");
    send(5'd8, 64'hDEAD_0000_FFFF_FFFF, 64'h1_FFFF_FFFF, 64'h1, "R6 muls32 -1*-1");
    send(5'd8, 64'h8000_0000, 64'h1, 64'hFFFF_FFFF_8000_0000, "R6 muls32 min*1");
    // R7 amount from low bits
    send(5'd15, 64'h1, 64'hFFFF_FFFF_FFFF_FF44, 64'h10, "R7 shl upper B ignored");
    send(5'd16, 64'h100, 64'h8000_0000_0000_0048, 64'h1, "R7 shr upper B ignored");
    // R8 arithmetic vs logical
    send(5'd17, 64'h8000_0000_0000_0000, 64'd63, '1, "R8 sar fill ones");
    send(5'd16, 64'h8000_0000_0000_0000, 64'd63, 64'h1, "R8 shr fill zeros");
    send(5'd17, 64'h4000_0000_0000_0000, 64'd62, 64'h1, "R8 sar positive");
    // R9 rotates
    send(5'd18, 64'h8000_0000_0000_0001, 64'd1, 64'h3, "R9 rol");
    send(5'd19, 64'h1, 64'd1, 64'h8000_0000_0000_0000, "R9 ror");
    send(5'd19, 64'h0123_4567_89AB_CDEF, 64'd4, 64'hF012_3456_789A_BCDE, "R9 ror nibble");
    // R10 zero amount
    send(5'd15, 64'h0123_4567_89AB_CDEF, 64'h0, 64'h0123_4567_89AB_CDEF, "R10 shl zero");
    send(5'd19, 64'h0123_4567_89AB_CDEF, 64'h40, 64'h0123_4567_89AB_CDEF, "R10 ror zero");
    send(5'd17, 64'h8765_4321_0FED_CBA9, 64'hFFC0, 64'h8765_4321_0FED_CBA9, "R10 sar zero");
    // R11 unused codes
    send(5'd20, 64'hCAFE_F00D_1234_5678, '1, 64'hCAFE_F00D_1234_5678, "R11 code 20");
    send(5'd31, 64'h0BAD_BEEF_0000_0001, 64'h5, 64'h0BAD_BEEF_0000_0001, "R11 code 31");

    // R12 gap: no result while idle
    idle(1);
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R12: out_valid got %b expected 0 while idle", out_valid);
    end

    // broad sweep against the model
    for (int i = 0; i < 400; i++) begin
      logic [63:0] a, b;
      logic [4:0]  o;
      a = {$urandom, $urandom};
      b = {$urandom, $urandom};
      if (i % 7 == 0) a[63] = 1'b1;
      o = 5'(i % 24);
      send(o, a, b, model(o, a, b), "R1 R2 R3 R4 R5 R6 R7 R8 R9 R11 sweep");
      if (i % 50 == 49) idle(2);
    end
    idle(3);

    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R12: results missing got %0d pending expected 0", exp_q.size());
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule